// File: doc/BRIEF.md
# Two-Channel DAC Register Controller

This block is the digital front end of an 8-bit digital-to-analog converter with two channels. A small register bus holds one code register per channel and one shared control register. Each channel has its own output-enable bit in the control register. Each channel has a timer that stands in for the analog settling time. A new code reaches the channel output only after that time has run out.

Software loads a code while the channel is disabled and its pin is undriven. It then sets the channel's enable bit. The pin is driven from the next cycle. The code appears, with its valid flag, once the conversion time has passed. Rewriting the code while the channel is enabled restarts the timer. Until the new conversion finishes, the old result stays on the output. Clearing the enable bit releases the pin at once and drops any conversion in flight. The analog level is the code divided by 256 times the reference, so the block exports the raw code.

Top module: `dac_pair_ctrl`

## Requirements
- R1: A synchronous active-low reset clears both code registers and both enable bits. After reset, every output code is 0, both valid flags are 0, both drive enables are 0 and the timers are idle.
- R2: The register offsets are 0 for the channel-0 code, 1 for the channel-1 code and 2 for control. In the control register, bit 6 enables channel 0 and bit 7 enables channel 1. The other control bits are not stored and read 0, and offset 3 reads 0. `bus_rdata` shows the addressed register combinationally and reflects a write from the cycle after it.
- R3: A code written while its channel is disabled is stored and can be read back, but it leaves that channel's drive, valid and code outputs at 0.
- R4: A control write that raises a channel's enable bit sets its drive from the next cycle. The valid flag stays low, and the stored code appears with valid high exactly CONV_CYCLES cycles after the write edge.
- R5: A code write to an enabled channel restarts its conversion. The new code appears exactly CONV_CYCLES cycles after that write. Until then, the previous code and valid flag stay on the output unchanged.
- R6: A code write during a pending conversion reloads the timer. The value that was pending is never presented.
- R7: A control write that clears a channel's enable bit sets that channel's drive and valid to 0 and its code to 0 from the next cycle. It also discards any pending conversion. A later enable starts a full conversion again.
- R8: The two channels convert independently. Writes to one channel's code or enable bit never change the other channel's outputs or timing.
- R9: A control write that leaves an already-set enable bit set does not restart or disturb that channel's conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| out_code | output | 16 | Output codes, channel 0 in bits 7:0, channel 1 in bits 15:8 |
| out_valid | output | 2 | Per-channel flag: a finished result is on the output |
| out_drive | output | 2 | Per-channel pin drive enable (0 means high impedance) |

## Verification
The assertions assume CONV_CYCLES is at least 1. They also assume the bus offers at most one write per cycle, so a code write and a control write never land on the same edge. The bench drives one operation per cycle from tasks, which keeps it within that assumption. Its random phase draws only offsets 0 to 3 and complete bytes. The checks at the enable and disable edges rely on the control-write data being the whole new control value. The bench always writes the full byte.

// File: rtl/dac_pair_pkg.sv
// Package: shared constants and types for the two-channel DAC controller.
// Assumes an 8-bit code and two channels; the register offsets below are
// the software-visible map and must not be reordered.
package dac_pair_pkg;

    localparam int DAC_W   = 8;   // code width per channel
    localparam int NUM_CH  = 2;   // number of converter channels
    localparam int REG_AW  = 2;   // register offset width
    localparam int EN_LSB  = 6;   // control bit of channel 0 enable

    typedef enum logic [REG_AW-1:0] {
        REG_CODE0 = 2'd0,
        REG_CODE1 = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } dac_reg_e;

    // Per-channel control from the register bank to the converter timer.
    typedef struct packed {
        logic en;     // enable bit currently set
        logic start;  // begin (or restart) a conversion at this edge
        logic stop;   // enable is being cleared at this edge
    } ch_ctl_t;

endpackage

// File: rtl/dac_reg_bank.sv
// Register bank: holds the per-channel code registers and the enable bits,
// serves combinational reads, and derives the start/stop pulses per channel.
// Assumes at most one write per cycle on the bus.
module dac_reg_bank
    import dac_pair_pkg::*;
#(
    parameter int DATA_W = DAC_W,
    parameter int CH_N   = NUM_CH
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [REG_AW-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [CH_N-1:0][DATA_W-1:0]    code_q,
    output ch_ctl_t [CH_N-1:0]             ctl
);

    logic [CH_N-1:0] en_q;
    logic [CH_N-1:0] sel_code;
    logic [CH_N-1:0] en_wr_bit;
    logic            wr_ctrl;

    assign wr_ctrl = bus_wr && (dac_reg_e'(bus_addr) == REG_CTRL);

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        assign sel_code[ch]  = bus_wr && (bus_addr == REG_AW'(ch));
        assign en_wr_bit[ch] = bus_wdata[EN_LSB + ch];

        // Capture the channel code on a write to its offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[ch] <= '0;
            end else if (sel_code[ch]) begin
                code_q[ch] <= bus_wdata;
            end
        end

        // Capture the channel enable bit on a control write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[ch] <= 1'b0;
            end else if (wr_ctrl) begin
                en_q[ch] <= en_wr_bit[ch];
            end
        end

        // Derive the timer controls: rising enable or code rewrite starts.
        always_comb begin
            ctl[ch].en    = en_q[ch];
            ctl[ch].start = (wr_ctrl && en_wr_bit[ch] && !en_q[ch])
                          || (sel_code[ch] && en_q[ch]);
            ctl[ch].stop  = wr_ctrl && !en_wr_bit[ch] && en_q[ch];
        end
    end

    // Read multiplexer over the register map; unused bits read zero.
    always_comb begin
        bus_rdata = '0;
        case (dac_reg_e'(bus_addr))
            REG_CODE0: bus_rdata = code_q[0];
            REG_CODE1: bus_rdata = code_q[1];
            REG_CTRL: begin
                for (int ch = 0; ch < CH_N; ch++) begin
                    bus_rdata[EN_LSB + ch] = en_q[ch];
                end
            end
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dac_conv_channel.sv
// One converter channel: a down-counter models the settling time, the
// finished result is held until replaced or the channel is disabled.
// Assumes start and stop are never asserted together and CONV_CYCLES >= 1.
module dac_conv_channel
    import dac_pair_pkg::*;
#(
    parameter int DATA_W      = DAC_W,
    parameter int CONV_CYCLES = 4,
    localparam int CNT_W      = $clog2(CONV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ch_ctl_t           ctl,
    input  logic [DATA_W-1:0] code_in,
    output logic [DATA_W-1:0] code_out,
    output logic              valid,
    output logic              drive
);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] result_q;
    logic              valid_q;

    // Conversion timer and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else if (ctl.stop) begin
            cnt_q    <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else if (ctl.start) begin
            cnt_q    <= CNT_W'(CONV_CYCLES);
        end else if (cnt_q == CNT_W'(1)) begin
            cnt_q    <= '0;
            result_q <= code_in;
            valid_q  <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q    <= cnt_q - CNT_W'(1);
        end
    end

    // Pin drive follows the enable bit directly.
    assign drive    = ctl.en;
    assign code_out = result_q;
    assign valid    = valid_q;

endmodule

// File: rtl/dac_pair_ctrl.sv
// Top: two-channel DAC register controller. Bus writes land in the register
// bank, each channel timer produces a held code, a valid flag and a drive
// enable. Assumes one bus write per cycle and CONV_CYCLES >= 1.
module dac_pair_ctrl
    import dac_pair_pkg::*;
#(
    parameter int CONV_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [REG_AW-1:0]         bus_addr,
    input  logic [DAC_W-1:0]          bus_wdata,
    output logic [DAC_W-1:0]          bus_rdata,
    output logic [NUM_CH*DAC_W-1:0]   out_code,
    output logic [NUM_CH-1:0]         out_valid,
    output logic [NUM_CH-1:0]         out_drive
);

    logic [NUM_CH-1:0][DAC_W-1:0] code_q;
    ch_ctl_t [NUM_CH-1:0]         ctl;

    dac_reg_bank #(
        .DATA_W (DAC_W),
        .CH_N   (NUM_CH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .code_q    (code_q),
        .ctl       (ctl)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_conv
        dac_conv_channel #(
            .DATA_W      (DAC_W),
            .CONV_CYCLES (CONV_CYCLES)
        ) u_conv (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (ctl[ch]),
            .code_in  (code_q[ch]),
            .code_out (out_code[ch*DAC_W +: DAC_W]),
            .valid    (out_valid[ch]),
            .drive    (out_drive[ch])
        );
    end

endmodule

// File: rtl/dac_pair_chk.sv
// Checker: port-level properties of the two-channel DAC controller, bound
// to every instance of the top. Assumes one bus write per cycle.
module dac_pair_chk
    import dac_pair_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [REG_AW-1:0]       bus_addr,
    input logic [DAC_W-1:0]        bus_wdata,
    input logic [NUM_CH*DAC_W-1:0] out_code,
    input logic [NUM_CH-1:0]       out_valid,
    input logic [NUM_CH-1:0]       out_drive
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (out_drive == '0 && out_valid == '0 && out_code == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_undriven_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !out_drive[c] |-> (!out_valid[c] && out_code[c*DAC_W +: DAC_W] == '0));

        assert_enable_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == REG_AW'(REG_CTRL) && bus_wdata[EN_LSB + c])
            |=> out_drive[c]);

        assert_valid_after_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_valid[c]) |-> $past(out_drive[c]));

        assert_hold_on_rewrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == REG_AW'(c) && out_valid[c])
            |=> (out_valid[c] && $stable(out_code[c*DAC_W +: DAC_W])));

        assert_disable_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == REG_AW'(REG_CTRL) && !bus_wdata[EN_LSB + c])
            |=> (!out_drive[c] && !out_valid[c]));
    end

endmodule

bind dac_pair_ctrl dac_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .out_code  (out_code),
    .out_valid (out_valid),
    .out_drive (out_drive)
);

// File: tb/test_dac_pair_ctrl.sv
`timescale 1ns/1ps
module test_dac_pair_ctrl;

    localparam int CONV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [15:0] out_code;
    logic [1:0]  out_valid;
    logic [1:0]  out_drive;

    always #2 clk = ~clk;

    dac_pair_ctrl #(.CONV_CYCLES(CONV)) i_dac_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_code(out_code),
        .out_valid(out_valid), .out_drive(out_drive)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string req     = "R1";
    bit    finished = 0;

    // Behavioural reference state per channel.
    int m_data[2];
    int m_en[2];
    int m_rem[2];
    int m_res[2];
    int m_vld[2];
    int nx_en;
    int wr_code;

    // Reference model, advanced on every rising edge from the bus inputs.
    always @(posedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            if (!rst_n) begin
                m_data[ch] = 0; m_en[ch] = 0; m_rem[ch] = 0;
                m_res[ch] = 0; m_vld[ch] = 0;
            end else begin
                nx_en   = (bus_wr && bus_addr == 2) ? int'(bus_wdata[6+ch]) : m_en[ch];
                wr_code = (bus_wr && bus_addr == ch) ? 1 : 0;
                if (m_en[ch] == 1 && nx_en == 0) begin
                    m_rem[ch] = 0; m_vld[ch] = 0; m_res[ch] = 0;
                end else if (m_en[ch] == 0 && nx_en == 1) begin
                    m_rem[ch] = CONV;
                end else if (nx_en == 1 && wr_code == 1) begin
                    m_rem[ch] = CONV;
                end else if (m_rem[ch] == 1) begin
                    m_res[ch] = m_data[ch]; m_vld[ch] = 1; m_rem[ch] = 0;
                end else if (m_rem[ch] > 0) begin
                    m_rem[ch] = m_rem[ch] - 1;
                end
                m_en[ch] = nx_en;
                if (wr_code == 1) m_data[ch] = int'(bus_wdata);
            end
        end
    end

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_data[0];
            1: return m_data[1];
            2: return (m_en[1] << 7) | (m_en[0] << 6);
            default: return 0;
        endcase
    endfunction

    task automatic check_one(string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        for (int ch = 0; ch < 2; ch++) begin
            check_one($sformatf("code%0d", ch), int'(out_code[ch*8 +: 8]), m_res[ch]);
            check_one($sformatf("valid%0d", ch), int'(out_valid[ch]), m_vld[ch]);
            check_one($sformatf("drive%0d", ch), int'(out_drive[ch]), m_en[ch]);
        end
        check_one("rdata", int'(bus_rdata), exp_rdata(int'(bus_addr)));
    endtask

    // One bus cycle: compare away from the edge, then set the next inputs.
    task automatic step(bit wr, int addr, int wdata);
        @(negedge clk);
        compare_all();
        bus_wr    = wr;
        bus_addr  = addr[1:0];
        bus_wdata = wdata[7:0];
    endtask

    task automatic idle(int n, int addr);
        for (int i = 0; i < n; i++) step(0, addr, 0);
    endtask

    task automatic wr(int addr, int data);
        step(1, addr, data);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got no end expected end");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state of outputs and registers
        req = "R1"; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        idle(1, 0);
        rst_n = 1'b1;
        idle(1, 2);
        // R3: codes loaded while disabled stay off the pins
        req = "R3"; wr(0, 8'h5A); wr(1, 8'hC3); idle(3, 0); idle(2, 1);
        // R2: register map and readback, unused control bits read zero
        req = "R2"; wr(2, 8'h3F); idle(2, 2); idle(2, 3); idle(1, 0);
        // R4: enabling channel 0 drives at once, valid after CONV cycles
        req = "R4"; wr(2, 8'h40); idle(CONV + 3, 2);
        // R5: rewrite while enabled keeps old result until new one lands
        req = "R5"; wr(0, 8'h80); idle(CONV + 3, 0);
        // R6: back-to-back rewrites drop the pending value
        req = "R6"; wr(0, 8'h11); idle(2, 0); wr(0, 8'h22); idle(1, 0);
        wr(0, 8'h33); idle(CONV + 3, 0);
        // R8: channel 1 enabled while channel 0 converts
        req = "R8"; wr(2, 8'hC0); idle(2, 2); wr(0, 8'h44); idle(CONV + 3, 1);
        // R9: repeated enable write mid-conversion does not restart
        req = "R9"; wr(1, 8'h99); idle(2, 1); wr(2, 8'hC0); idle(CONV + 3, 2);
        // R7: disabling mid-conversion releases pin and discards result
        req = "R7"; wr(0, 8'h10); idle(1, 0); wr(2, 8'h80); idle(CONV + 2, 2);
        wr(2, 8'hC0); idle(CONV + 3, 0);
        // R8: random mix of writes to both channels and control
        req = "R8"; lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[1]) wr(int'(lfsr[3:2]), int'(lfsr[15:8]));
            else idle(1, int'(lfsr[5:4]));
        end
        // R1: reset in the middle of activity
        req = "R1"; wr(2, 8'hC0); wr(0, 8'h77); rst_n = 1'b0; idle(2, 2);
        rst_n = 1'b1; idle(2, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule